// File: doc/BRIEF.md
# HDLC Frame Receiver

This block turns a serial line into a stream of frame bytes. A one-bit input comes with a bit-enable strobe. The receiver watches every received bit for the 01111110 delimiter, and once one is seen it treats the bits that follow as frame content. Inside a frame it removes the zero that the sender stuffed after each run of five ones. It packs the surviving bits into bytes, least significant bit first, and runs a bit-serial CRC-16 over them. It also counts how many content bits arrived.

At each closing delimiter the frame length and the CRC residue decide what happens to the bytes held back in a short delay line:
- A frame that is too short vanishes.
- A frame in the intermediate band is written out with a bad tag on its last byte.
- A full-length frame is written out without its two check bytes, with an end tag and a bad tag that reflects the CRC.

Seven ones in a row inside a frame abort it: the receiver stops writing and waits for the next delimiter.

The output is a one-cycle byte strobe with end and bad tags, meant to feed an external receive FIFO directly.

Top module: `hdlc_rx`

## Requirements
- R1: While reset is asserted and after it is released with no input, out_valid, out_eop and out_bad are 0.
- R2: The receiver matches the pattern 01111110 at every bit position. Bits received before the first such pattern, or after an abort and before the next pattern, produce no output.
- R3: Inside a frame, a 0 that follows five consecutive 1 bits is removed and is neither counted nor stored.
- R4: Content bits are packed first-received into bit 0. The CRC starts at FFFFh at each delimiter and shifts right one bit per content bit. For each bit, when the register's bit 0 XOR the new bit is 1, the shifted value is XORed with 8408h. A frame of 32 or more content bits whose final register value is F0B8h is written out without its last two bytes; its last written byte has out_eop=1 and out_bad=0.
- R5: A frame of 32 or more content bits whose register value is not F0B8h is written out the same way, but its last written byte has out_eop=1 and out_bad=1.
- R6: A frame with fewer than 25 content bits produces no output.
- R7: A frame with 25 to 31 content bits writes its first three bytes on three consecutive clock cycles, and only the third has out_eop=1 and out_bad=1.
- R8: Seven consecutive 1 bits inside a frame abort it. Bytes already written stay, no further byte and no end tag appear for that frame, and the receiver hunts for the next delimiter.
- R9: Back-to-back delimiters with nothing between them produce no output. A single delimiter both closes one frame and opens the next.
- R10: out_valid is a single-cycle strobe per byte. out_eop is 1 only with out_valid, and out_bad is 1 only with out_eop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Strobe: bit_in carries a line bit this cycle |
| bit_in | input | 1 | Serial line bit |
| out_valid | output | 1 | A byte is presented this cycle |
| out_data | output | 8 | Frame byte, first received bit in bit 0 |
| out_eop | output | 1 | Byte is the last one of its frame |
| out_bad | output | 1 | Frame ending on this byte is invalid |

## Verification
The assertions assume that two delimiters are never less than three clock cycles apart. This always holds, because a delimiter needs eight strobed bits, so a new close can never overlap the tail of a previous write-out. They also assume that reset lasts long enough to clear the delay line.

The bench drives only well-formed line traffic. Frame content is always stuffed by the bench's own encoder, and noise before a delimiter never contains more than two ones in a row, so no stray delimiter is formed. The bench also spaces strobes with gaps of idle cycles to show that timing depends on bit_en and not on the clock.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

  // Number of delimiter bits that reach the content path before the
  // delimiter is recognised: the leading 0 and five 1s.
  localparam int FLAG_LAG = 6;
  localparam logic [7:0] FLAG_PAT = 8'h7E;
  localparam logic [15:0] CRC_POLY_REV = 16'h8408;
  localparam logic [15:0] CRC_PRESET = 16'hFFFF;
  localparam int FCS_BYTES = 2;

  typedef enum logic [1:0] {
    LEN_DROP      = 2'd0,
    LEN_SHORT_BAD = 2'd1,
    LEN_FULL      = 2'd2
  } len_class_e;

  // One bit of the reflected CRC-16 update.
  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b);
    logic [15:0] sh;
    sh = c >> 1;
    crc_step = (c[0] ^ b) ? (sh ^ CRC_POLY_REV) : sh;
  endfunction

  // Length grading of a finished frame.
  function automatic len_class_e classify(input int unsigned len,
                                          input int unsigned keep_min,
                                          input int unsigned good_min);
    if (len < keep_min)      classify = LEN_DROP;
    else if (len < good_min) classify = LEN_SHORT_BAD;
    else                     classify = LEN_FULL;
  endfunction

endpackage

// File: rtl/hdlc_rx_lineside.sv
module hdlc_rx_lineside
  import hdlc_rx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic bit_in,
  output logic flag_evt,
  output logic abort_evt,
  output logic in_frame,
  output logic fbit_vld,
  output logic fbit
);
  localparam int FILL_W = $clog2(FLAG_LAG + 1);
  localparam logic [FILL_W-1:0] FILL_FULL = FILL_W'(FLAG_LAG);

  logic [7:0]          win;
  logic [2:0]          ones;
  logic [FLAG_LAG-1:0] lag;
  logic [FILL_W-1:0]   fill;
  logic                framing;

  logic [7:0] win_nxt;
  logic       stuffed;
  logic       run_hi;
  logic       push;

  assign win_nxt   = {win[6:0], bit_in};
  assign flag_evt  = bit_en && (win_nxt == FLAG_PAT);
  assign abort_evt = bit_en && framing && bit_in && (ones == 3'd6);
  assign stuffed   = bit_en && !bit_in && (ones == 3'd5);
  assign run_hi    = bit_in && (ones >= 3'd5);
  assign push      = bit_en && framing && !flag_evt && !stuffed && !run_hi;
  assign fbit_vld  = push && (fill == FILL_FULL);
  assign fbit      = lag[FLAG_LAG-1];
  assign in_frame  = framing;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win     <= '0;
      ones    <= '0;
      lag     <= '0;
      fill    <= '0;
      framing <= 1'b0;
    end else if (bit_en) begin
      win <= win_nxt;
      if (bit_in) ones <= (ones == 3'd7) ? ones : ones + 3'd1;
      else        ones <= '0;
      if (flag_evt)       framing <= 1'b1;
      else if (abort_evt) framing <= 1'b0;
      if (flag_evt || abort_evt) begin
        fill <= '0;
      end else if (push) begin
        lag  <= {lag[FLAG_LAG-2:0], bit_in};
        fill <= (fill == FILL_FULL) ? fill : fill + 1'b1;
      end
    end
  end

  // Run of ones that actually entered the content path.
  logic [2:0] push_run;
  always_ff @(posedge clk) begin
    if (!rst_n) push_run <= '0;
    else if (flag_evt || abort_evt || stuffed) push_run <= '0;
    else if (push) push_run <= bit_in ? push_run + 3'd1 : 3'd0;
  end

  // R3: stuffed zeros gone, the content path never sees six ones in a row
  a_r3_no_six_ones: assert property (@(posedge clk) disable iff (!rst_n)
    push_run <= 3'd5);

  // R8: an abort leaves the frame state
  a_r8_abort_leaves_frame: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> !in_frame);

endmodule

// File: rtl/hdlc_rx_frame_acc.sv
module hdlc_rx_frame_acc
  import hdlc_rx_pkg::*;
#(
  parameter int LEN_W = 12,
  parameter logic [15:0] CRC_RESIDUE = 16'hF0B8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             fbit_vld,
  input  logic             fbit,
  output logic             byte_done,
  output logic [7:0]       byte_val,
  output logic [LEN_W-1:0] frame_len,
  output logic             crc_ok
);
  logic [15:0] crc;
  logic [7:0]  sr;
  logic [2:0]  bcnt;

  assign byte_done = fbit_vld && (bcnt == 3'd7);
  assign byte_val  = {fbit, sr[7:1]};
  assign crc_ok    = (crc == CRC_RESIDUE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      crc       <= CRC_PRESET;
      sr        <= '0;
      bcnt      <= '0;
      frame_len <= '0;
    end else if (start) begin
      crc       <= CRC_PRESET;
      bcnt      <= '0;
      frame_len <= '0;
    end else if (fbit_vld) begin
      crc  <= crc_step(crc, fbit);
      sr   <= {fbit, sr[7:1]};
      bcnt <= bcnt + 3'd1;
      if (frame_len != '1) frame_len <= frame_len + 1'b1;
    end
  end

  // R4: a byte completes exactly on an octet boundary of the content length
  a_r4_byte_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |-> (frame_len[2:0] == 3'd7));

  // R9: a delimiter restarts the length count
  a_r9_len_restart: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (frame_len == '0));

endmodule

// File: rtl/hdlc_rx_emit.sv
module hdlc_rx_emit
  import hdlc_rx_pkg::*;
#(
  parameter int LEN_W    = 12,
  parameter int KEEP_MIN = 25,
  parameter int GOOD_MIN = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             close,
  input  logic             abort,
  input  logic             byte_done,
  input  logic [7:0]       byte_val,
  input  logic [LEN_W-1:0] frame_len,
  input  logic             crc_ok,
  output logic             out_valid,
  output logic [7:0]       out_data,
  output logic             out_eop,
  output logic             out_bad
);
  localparam int HOLD  = FCS_BYTES + 1;
  localparam int CNT_W = $clog2(HOLD + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(HOLD);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [7:0]       q [HOLD];
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] drain;
  len_class_e       cls;

  assign cls = classify(32'(frame_len), 32'(KEEP_MIN), 32'(GOOD_MIN));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < HOLD; i++) q[i] <= '0;
      cnt       <= '0;
      drain     <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_eop   <= 1'b0;
      out_bad   <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      out_eop   <= 1'b0;
      out_bad   <= 1'b0;
      if (drain != '0) begin
        out_valid <= 1'b1;
        out_data  <= q[0];
        out_eop   <= (drain == ONE);
        out_bad   <= (drain == ONE);
        for (int i = 0; i < HOLD - 1; i++) q[i] <= q[i+1];
        drain <= drain - ONE;
      end else if (close) begin
        cnt <= '0;
        if (cls == LEN_FULL) begin
          out_valid <= 1'b1;
          out_data  <= q[0];
          out_eop   <= 1'b1;
          out_bad   <= !crc_ok;
        end else if (cls == LEN_SHORT_BAD) begin
          out_valid <= 1'b1;
          out_data  <= q[0];
          for (int i = 0; i < HOLD - 1; i++) q[i] <= q[i+1];
          drain <= CNT_W'(HOLD - 1);
        end
      end else if (abort) begin
        cnt <= '0;
      end else if (byte_done) begin
        if (cnt == CNT_FULL) begin
          out_valid <= 1'b1;
          out_data  <= q[0];
          for (int i = 0; i < HOLD - 1; i++) q[i] <= q[i+1];
          q[HOLD-1] <= byte_val;
        end else begin
          for (int i = 0; i < HOLD; i++)
            if (cnt == CNT_W'(i)) q[i] <= byte_val;
          cnt <= cnt + ONE;
        end
      end
    end
  end

  // R10: tag ordering on the output
  a_r10_eop_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_eop |-> out_valid);
  a_r10_bad_needs_eop: assert property (@(posedge clk) disable iff (!rst_n)
    out_bad |-> out_eop);

  // R6: short frames leave nothing behind
  a_r6_short_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (close && cls == LEN_DROP) |=> !out_valid);

  // R9: an empty frame between delimiters writes nothing
  a_r9_empty_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (close && frame_len == '0) |=> !out_valid);

  // R4: a full frame has the hold line filled and ends with a tagged byte
  a_r4_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (close && cls == LEN_FULL) |-> (cnt == CNT_FULL));
  a_r4_full_tag: assert property (@(posedge clk) disable iff (!rst_n)
    (close && cls == LEN_FULL) |=> (out_valid && out_eop));

  // R7: mid-band frames write three bytes, the last one tagged bad
  a_r7_band_three: assert property (@(posedge clk) disable iff (!rst_n)
    (close && cls == LEN_SHORT_BAD) |=> (out_valid && !out_eop)
      ##1 (out_valid && !out_eop) ##1 (out_valid && out_eop && out_bad));

  // R7: no new close lands while a write-out is still running
  a_r7_no_close_in_drain: assert property (@(posedge clk) disable iff (!rst_n)
    (drain != '0) |-> !close);

  // R8: an abort writes nothing on the next cycle
  a_r8_abort_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !out_valid);

endmodule

// File: rtl/hdlc_rx.sv
module hdlc_rx
  import hdlc_rx_pkg::*;
#(
  parameter int LEN_W    = 12,
  parameter int KEEP_MIN = 25,
  parameter int GOOD_MIN = 32,
  parameter logic [15:0] CRC_RESIDUE = 16'hF0B8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_en,
  input  logic       bit_in,
  output logic       out_valid,
  output logic [7:0] out_data,
  output logic       out_eop,
  output logic       out_bad
);
  logic             flag_evt;
  logic             abort_evt;
  logic             in_frame;
  logic             fbit_vld;
  logic             fbit;
  logic             close_evt;
  logic             byte_done;
  logic [7:0]       byte_val;
  logic [LEN_W-1:0] frame_len;
  logic             crc_ok;

  assign close_evt = flag_evt && in_frame;

  hdlc_rx_lineside u_line (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_en    (bit_en),
    .bit_in    (bit_in),
    .flag_evt  (flag_evt),
    .abort_evt (abort_evt),
    .in_frame  (in_frame),
    .fbit_vld  (fbit_vld),
    .fbit      (fbit)
  );

  hdlc_rx_frame_acc #(
    .LEN_W       (LEN_W),
    .CRC_RESIDUE (CRC_RESIDUE)
  ) u_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (flag_evt),
    .fbit_vld  (fbit_vld),
    .fbit      (fbit),
    .byte_done (byte_done),
    .byte_val  (byte_val),
    .frame_len (frame_len),
    .crc_ok    (crc_ok)
  );

  hdlc_rx_emit #(
    .LEN_W    (LEN_W),
    .KEEP_MIN (KEEP_MIN),
    .GOOD_MIN (GOOD_MIN)
  ) u_emit (
    .clk       (clk),
    .rst_n     (rst_n),
    .close     (close_evt),
    .abort     (abort_evt),
    .byte_done (byte_done),
    .byte_val  (byte_val),
    .frame_len (frame_len),
    .crc_ok    (crc_ok),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_eop   (out_eop),
    .out_bad   (out_bad)
  );

  // R2: content bits only flow while a frame is open
  a_r2_content_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    fbit_vld |-> in_frame);

endmodule

// File: tb/hdlc_rx_bench.sv
`timescale 1ns/1ps
module hdlc_rx_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_en = 1'b0;
  logic       bit_in = 1'b0;
  logic       out_valid;
  logic [7:0] out_data;
  logic       out_eop;
  logic       out_bad;

  always #2.5 clk = ~clk;

  hdlc_rx u_hdlc_rx (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
    .out_valid(out_valid), .out_data(out_data), .out_eop(out_eop), .out_bad(out_bad)
  );

  int checks = 0;
  int errors = 0;
  int gap = 0;
  int proto_bad = 0;
  bit fb[$];
  logic [9:0] expq[$];
  logic [9:0] gotq[$];

  // capture: {eop, bad, data}
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) gotq.push_back({out_eop, out_bad, out_data});
      if ((out_eop && !out_valid) || (out_bad && !out_eop)) proto_bad++;
    end
  end

  task automatic tx_raw(input bit b);
    @(negedge clk);
    bit_en = 1'b1;
    bit_in = b;
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      bit_en = 1'b0;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bit_en = 1'b0;
    end
  endtask

  task automatic tx_flag();
    for (int i = 0; i < 8; i++) tx_raw((i == 0 || i == 7) ? 1'b0 : 1'b1);
  endtask

  // R3: bench-side encoder inserts a 0 after five 1s
  task automatic tx_body();
    int run;
    run = 0;
    foreach (fb[i]) begin
      tx_raw(fb[i]);
      run = fb[i] ? run + 1 : 0;
      if (run == 5) begin
        tx_raw(1'b0);
        run = 0;
      end
    end
  endtask

  task automatic add_byte(input logic [7:0] v);
    for (int j = 0; j < 8; j++) fb.push_back(v[j]);
  endtask

  function automatic logic [15:0] ref_crc();
    logic [15:0] c;
    c = 16'hFFFF;
    foreach (fb[i]) begin
      if ((c[0] ^ fb[i]) == 1'b1) c = (c >> 1) ^ 16'h8408;
      else c = c >> 1;
    end
    return c;
  endfunction

  task automatic add_fcs();
    logic [15:0] f;
    f = ~ref_crc();
    for (int j = 0; j < 16; j++) fb.push_back(f[j]);
  endtask

  function automatic logic [7:0] fb_byte(input int k);
    logic [7:0] v;
    for (int j = 0; j < 8; j++) v[j] = fb[8*k + j];
    return v;
  endfunction

  // Expected output for a frame closed by a delimiter (R4 R5 R6 R7)
  task automatic model_frame();
    int len;
    int nb;
    bit ok;
    len = fb.size();
    if (len < 25) return;
    if (len < 32) begin
      for (int k = 0; k < 3; k++)
        expq.push_back({(k == 2), (k == 2), fb_byte(k)});
      return;
    end
    nb = len / 8;
    ok = (ref_crc() == 16'hF0B8);
    for (int k = 0; k <= nb - 3; k++)
      expq.push_back({(k == nb - 3), (k == nb - 3) && !ok, fb_byte(k)});
  endtask

  task automatic finish_case(input string tag);
    idle(10);
    checks++;
    if (gotq.size() != expq.size()) begin
      errors++;
      $display("FAIL %s: byte count actual %0d expected %0d", tag, gotq.size(), expq.size());
    end
    for (int i = 0; i < expq.size() && i < gotq.size(); i++) begin
      checks++;
      if (gotq[i] !== expq[i]) begin
        errors++;
        $display("FAIL %s: entry %0d actual %h expected %h", tag, i, gotq[i], expq[i]);
      end
    end
    gotq.delete();
    expq.delete();
  endtask

  task automatic run_frame(input string tag);
    tx_flag();
    tx_body();
    tx_flag();
    model_frame();
    finish_case(tag);
    fb.delete();
  endtask

  task automatic tx_abort();
    tx_raw(1'b0);
    for (int i = 0; i < 7; i++) tx_raw(1'b1);
    for (int i = 0; i < 4; i++) tx_raw(1'b1);
  endtask

  task automatic tx_noise(input int n);
    for (int i = 0; i < n; i++) tx_raw((i % 3) != 0);
  endtask

  task automatic good_frame(input int n, input int seed);
    for (int k = 0; k < n; k++) add_byte(8'((seed * 37 + k * 91 + 5) & 8'hFF));
    add_fcs();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_eop !== 1'b0 || out_bad !== 1'b0) begin
      errors++;
      $display("FAIL R1 in reset: actual %b%b%b expected 000", out_valid, out_eop, out_bad);
    end
    rst_n = 1'b1;
    idle(4);
    checks++;
    if (out_valid !== 1'b0 || out_eop !== 1'b0 || out_bad !== 1'b0 || gotq.size() != 0) begin
      errors++;
      $display("FAIL R1 after reset: actual %b%b%b expected 000", out_valid, out_eop, out_bad);
    end

    // R2: noise before the very first delimiter
    tx_noise(11);
    good_frame(3, 1);
    run_frame("R2 first frame after noise");

    // R4: good frames of several sizes
    for (int n = 2; n <= 8; n++) begin
      good_frame(n, n);
      run_frame("R4 good frame");
    end

    // R3: content heavy with ones and delimiter look-alikes
    add_byte(8'hFF); add_byte(8'hFF); add_byte(8'h7E);
    add_byte(8'h3F); add_byte(8'hF8); add_byte(8'hFC);
    add_fcs();
    run_frame("R3 stuffed content");

    // R5: corrupted check bits
    for (int n = 2; n <= 5; n++) begin
      good_frame(n, n + 20);
      fb[fb.size() - 1 - n] = ~fb[fb.size() - 1 - n];
      run_frame("R5 crc mismatch");
    end

    // R6 R7 R9: length sweep, every content length up to 40 bits
    for (int len = 0; len <= 40; len++) begin
      for (int i = 0; i < len; i++) fb.push_back(((i * 7 + len) % 5) < 3);
      if (len == 0) run_frame("R9 empty frame");
      else if (len < 25) run_frame("R6 short frame");
      else if (len < 32) run_frame("R7 mid-band frame");
      else run_frame("R5 long unchecked frame");
    end

    // R9: several delimiters in a row
    tx_flag(); tx_flag(); tx_flag();
    finish_case("R9 back-to-back delimiters");

    // R8: abort after six content bytes, then recovery through noise
    tx_flag();
    for (int k = 0; k < 6; k++) add_byte(8'((k * 29 + 3) & 8'h7F));
    tx_body();
    for (int k = 0; k < 3; k++) expq.push_back({2'b00, fb_byte(k)});
    tx_abort();
    finish_case("R8 abort keeps written bytes");
    fb.delete();
    tx_noise(7);
    finish_case("R2 noise after abort is ignored");
    good_frame(4, 9);
    run_frame("R8 recovery frame after abort");

    // R8: early abort writes nothing
    tx_flag();
    add_byte(8'h12);
    tx_body();
    fb.delete();
    tx_abort();
    finish_case("R8 early abort silent");

    // R2: delimiter found at different bit alignments after an abort
    for (int off = 0; off < 8; off++) begin
      tx_abort();
      tx_noise(off);
      good_frame(2, off + 40);
      run_frame("R2 alignment sweep");
    end

    // R4 R7: strobe gaps between bits
    gap = 2;
    good_frame(3, 77);
    run_frame("R4 good frame with gaps");
    for (int i = 0; i < 28; i++) fb.push_back((i % 4) != 0);
    run_frame("R7 mid-band with gaps");
    gap = 0;

    checks++;
    if (proto_bad != 0) begin
      errors++;
      $display("FAIL R10 tag ordering: actual %0d violations expected 0", proto_bad);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule